// File: doc/BRIEF.md
# Double-Buffered Bit-Stream Packer

This block takes a serial stream that delivers one data bit on every clock cycle, with no way to pause the source, and assembles the bits into fixed-size blocks in on-chip memory. It has two block buffers. While the host processor drains a filled buffer through a word-wide read port, the writer fills the other buffer. When a buffer fills, the writer raises an interrupt and starts on the other buffer with the next bit.

Each block starts with an 8-byte header. The header holds the stream index of the block's first payload bit and the payload length. With these two values the host can rebuild the continuous stream and find any gap. The host frees a buffer by pulsing an acknowledge for that buffer number.

A block may complete while the other buffer is still held by the host. In that case the writer drops bits until that buffer is freed and sets a sticky overflow flag. The stream index keeps advancing during the drop, so the header of the next block shows where the stream resumes.

Top module: `bitpack_dbuf`

## Requirements
- R1: A synchronous reset does the following:
  - clears both ready flags, the overflow flag, the completed-block count and the stream bit index;
  - makes `irq` low;
  - makes buffer 0 the target of the first block, whose header index is 0.
- R2: Payload bits are packed LSB-first, and the payload occupies the words from address 2 upward.
  - Payload bit k of a block sits in payload byte k/8, at bit k%8.
  - Each 32-bit word holds four bytes, with the lower-numbered byte in bits 7:0.
- R3: The header uses word addresses 0 and 1.
  - Word 0 holds bits 31:0 of the block's starting stream index.
  - Word 1 holds index bits 47:32 in bits 15:0 and the payload byte count (`PAYLOAD_BYTES`) in bits 31:16.
- R4: Completion happens on the clock edge that consumes the last payload bit of a block.
  - That edge sets the ready flag of the filled buffer and increments `blk_count`.
  - The next bit goes to the other buffer.
  - No flag is set earlier.
- R5: `irq` is high whenever any ready flag is set.
  - A ready flag stays set until an acknowledge arrives with `ack_valid` high and `ack_sel` equal to that buffer number (0 or 1).
  - The flag clears on that edge.
- R6: An acknowledge for a buffer that is not ready has no effect on either ready flag.
- R7: A block may be due to start while its target buffer is still ready. Then:
  - each incoming bit is discarded;
  - `overflow` is set and stays set until reset;
  - the stream index still advances;
  - the first bit that arrives after the buffer is freed becomes payload bit 0, and its stream index appears in the header.
- R8: An acknowledge of the other buffer may arrive on the same edge that completes a block. In that case the very next bit is accepted into the freed buffer, and `overflow` stays low.
- R9: When an acknowledge for the completing buffer arrives on its completion edge, completion wins and that buffer is left ready.
- R10: The read port returns the word at (`rd_bank`, `rd_addr`) one clock after the address is presented. Either buffer can be read at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data, one bit consumed each cycle |
| ack_valid | input | 1 | Acknowledge strobe from the host |
| ack_sel | input | 1 | Buffer number being acknowledged |
| rd_bank | input | 1 | Buffer selected for reading |
| rd_addr | input | AW | Word address within the selected buffer |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, high while any buffer is ready |
| ready | output | 2 | Per-buffer ready flags |
| overflow | output | 1 | Sticky flag showing that bits were dropped |
| blk_count | output | CNT_W | Completed-block count, wraps |

## Verification
Two functions can act in the same cycle: block completion, which sets a ready flag, and a host acknowledge, which clears one. The bench provokes both orders of interest by pulsing the acknowledge on the exact edge that consumes a block's last bit.

- When the acknowledge targets the other buffer, the bench judges the next block's header index (it must equal the next bit's number) and confirms that the overflow flag stayed low.
- When the acknowledge targets the completing buffer, it judges that the ready flag survived.

Dropped-bit gaps are judged the same way, through the header index of the block that follows.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    localparam int WORD_W    = 32;
    localparam int HDR_WORDS = 2;
    localparam int IDX_W     = 48;
    localparam int LEN_W     = 16;
    localparam int MADDR_W   = 16;

    // Kind of memory write the sequencer issues in a cycle
    typedef enum logic [1:0] {
        WK_NONE,
        WK_HDR_LO,
        WK_HDR_HI,
        WK_BODY
    } wkind_t;

    typedef struct packed {
        logic               en;
        logic               bank;
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } wr_req_t;

    // Upper header word: length in the top half, index bits 47:32 below
    function automatic logic [WORD_W-1:0] hdr_upper(input logic [15:0] idx_hi,
                                                    input logic [LEN_W-1:0] len);
        return {len, idx_hi};
    endfunction

endpackage

// File: rtl/bpk_packer.sv
module bpk_packer
    import bpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              din,
    output logic [WORD_W-1:0] word_now
);

    // Holds the previous WORD_W-1 accepted bits, oldest in bit 0
    logic [WORD_W-2:0] acc;

    assign word_now = {din, acc};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (take) begin
            acc <= word_now[WORD_W-1:1];
        end
    end

endmodule

// File: rtl/bpk_seq.sv
module bpk_seq
    import bpk_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 4096,
    parameter int CNT_W         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_valid,
    input  logic              ack_sel,
    input  logic [WORD_W-1:0] word_now,
    output logic              take,
    output wr_req_t           wr,
    output logic [1:0]        ready,
    output logic              overflow,
    output logic [CNT_W-1:0]  blk_count
);

    localparam int BITS  = PAYLOAD_BYTES * 8;
    localparam int POS_W = $clog2(BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BITS - 1);
    localparam logic [LEN_W-1:0] LEN_VAL  = LEN_W'(PAYLOAD_BYTES);

    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] stream_idx;
    logic [15:0]      start_hi;
    logic             wr_buf;
    logic             last;
    logic [1:0]       set_v;
    logic [1:0]       clr_v;
    logic [1:0]       ready_n;
    wkind_t           kind;

    // A new block may start only when its target buffer is free
    assign take = (pos != '0) || !ready[wr_buf];
    assign last = take && (pos == POS_LAST);

    generate
        for (genvar b = 0; b < 2; b++) begin : g_flag
            assign clr_v[b]   = ack_valid && (ack_sel == 1'(b));
            assign set_v[b]   = last && (wr_buf == 1'(b));
            // completion outranks a same-cycle acknowledge
            assign ready_n[b] = set_v[b] | (ready[b] & ~clr_v[b]);
        end
    endgenerate

    always_comb begin
        kind = WK_NONE;
        if (take) begin
            if (pos == POS_W'(0))          kind = WK_HDR_LO;
            else if (pos == POS_W'(1))     kind = WK_HDR_HI;
            else if (pos[4:0] == 5'd31)    kind = WK_BODY;
        end
    end

    always_comb begin
        wr      = '0;
        wr.bank = wr_buf;
        unique case (kind)
            WK_HDR_LO: begin
                wr.en   = 1'b1;
                wr.addr = MADDR_W'(0);
                wr.data = stream_idx[31:0];
            end
            WK_HDR_HI: begin
                wr.en   = 1'b1;
                wr.addr = MADDR_W'(1);
                wr.data = hdr_upper(start_hi, LEN_VAL);
            end
            WK_BODY: begin
                wr.en   = 1'b1;
                wr.addr = MADDR_W'(pos >> 5) + MADDR_W'(HDR_WORDS);
                wr.data = word_now;
            end
            default: wr.en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            stream_idx <= '0;
            start_hi   <= '0;
            wr_buf     <= 1'b0;
            ready      <= 2'b00;
            overflow   <= 1'b0;
            blk_count  <= '0;
        end else begin
            stream_idx <= stream_idx + IDX_W'(1);
            ready      <= ready_n;
            if (take) begin
                pos <= last ? '0 : pos + POS_W'(1);
            end
            if (kind == WK_HDR_LO) begin
                start_hi <= stream_idx[IDX_W-1:32];
            end
            if (last) begin
                wr_buf    <= ~wr_buf;
                blk_count <= blk_count + CNT_W'(1);
            end
            if (!take) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bpk_bank.sv
module bpk_bank
    import bpk_pkg::*;
#(
    parameter int WORDS = 1026,
    parameter int AW    = 11
) (
    input  logic              clk,
    input  wr_req_t           wr,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [2][WORDS];

    always_ff @(posedge clk) begin
        if (wr.en && (wr.addr < MADDR_W'(WORDS))) begin
            mem[wr.bank][wr.addr[AW-1:0]] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if ({1'b0, rd_addr} < (AW + 1)'(WORDS)) begin
            rd_data <= mem[rd_bank][rd_addr];
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/bitpack_dbuf.sv
module bitpack_dbuf
    import bpk_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 4096,
    parameter int CNT_W         = 16,
    parameter int AW            = $clog2(2 + PAYLOAD_BYTES / 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             ack_valid,
    input  logic             ack_sel,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_addr,
    output logic [31:0]      rd_data,
    output logic             irq,
    output logic [1:0]       ready,
    output logic             overflow,
    output logic [CNT_W-1:0] blk_count
);

    localparam int WORDS = HDR_WORDS + PAYLOAD_BYTES / 4;

    logic              take;
    logic [WORD_W-1:0] word_now;
    wr_req_t           wr;

    bpk_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .din      (bit_in),
        .word_now (word_now)
    );

    bpk_seq #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ack_valid (ack_valid),
        .ack_sel   (ack_sel),
        .word_now  (word_now),
        .take      (take),
        .wr        (wr),
        .ready     (ready),
        .overflow  (overflow),
        .blk_count (blk_count)
    );

    bpk_bank #(
        .WORDS (WORDS),
        .AW    (AW)
    ) u_bank (
        .clk     (clk),
        .wr      (wr),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign irq = |ready;

endmodule

// File: rtl/bitpack_dbuf_chk.sv
module bitpack_dbuf_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ack_valid,
    input logic             ack_sel,
    input logic             irq,
    input logic [1:0]       ready,
    input logic             overflow,
    input logic [CNT_W-1:0] blk_count
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (ready == 2'b00 && !overflow && blk_count == '0)); // R1

    AST_COUNT_ON_SET: assert property (@(posedge clk) disable iff (rst)
        ((ready & ~$past(ready)) != 2'b00) |-> (blk_count == $past(blk_count) + CNT_W'(1))); // R4

    AST_ONE_SET: assert property (@(posedge clk) disable iff (rst)
        $countones(ready & ~$past(ready)) <= 1); // R4

    AST_FALL0_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(ready[0]) |-> $past(ack_valid && !ack_sel)); // R5

    AST_FALL1_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(ready[1]) |-> $past(ack_valid && ack_sel)); // R5

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(irq) && !$past(ack_valid)) |-> irq); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(overflow) |-> overflow); // R7

endmodule

bind bitpack_dbuf bitpack_dbuf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_valid (ack_valid),
    .ack_sel   (ack_sel),
    .irq       (irq),
    .ready     (ready),
    .overflow  (overflow),
    .blk_count (blk_count)
);

// File: tb/sim_bitpack_dbuf.sv
`timescale 1ns/1ps
module sim_bitpack_dbuf;

    localparam int PB    = 8;
    localparam int CW    = 16;
    localparam int AWB   = 2;
    localparam int NBITS = PB * 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rst_d = 1'b1;
    logic           bit_in = 1'b0;
    logic           ack_valid = 1'b0;
    logic           ack_sel = 1'b0;
    logic           rd_bank = 1'b0;
    logic [AWB-1:0] rd_addr = '0;
    logic [31:0]    rd_data;
    logic           irq;
    logic [1:0]     ready;
    logic           overflow;
    logic [CW-1:0]  blk_count;

    int nidx = 0;
    int nchk = 0;
    int nfail = 0;
    int ncyc = 0;

    always #5 clk = ~clk;

    bitpack_dbuf #(.PAYLOAD_BYTES(PB), .CNT_W(CW), .AW(AWB)) u0 (
        .clk(clk), .rst(rst), .bit_in(bit_in), .ack_valid(ack_valid),
        .ack_sel(ack_sel), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .ready(ready), .overflow(overflow),
        .blk_count(blk_count)
    );

    function automatic logic pat(input int i);
        logic [31:0] v;
        v = i;
        return v[0] ^ v[2] ^ v[5] ^ (v[3] & v[1]) ^ v[7];
    endfunction

    function automatic logic [31:0] exp_word(input int start, input int w);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[k] = pat(start + 32 * w + k);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One stream cycle: drive at negedge, return just after posedge
    task automatic cyc(input logic av, input logic as);
        @(negedge clk);
        rst       = rst_d;
        bit_in    = pat(nidx);
        ack_valid = av;
        ack_sel   = as;
        @(posedge clk);
        #1;
        nidx++;
        ack_valid = 1'b0;
    endtask

    task automatic run_to(input int target);
        while (nidx < target) cyc(1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst_d = 1'b1;
        repeat (3) cyc(1'b0, 1'b0);
        rst_d = 1'b0;
        nidx  = 0;
    endtask

    task automatic rd_chk(input string tag, input logic b, input int a, input logic [31:0] exp);
        rd_bank = b;
        rd_addr = AWB'(a);
        cyc(1'b0, 1'b0);
        chk(tag, rd_data, exp);
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 100000) begin
            nchk++;
            nfail++;
            $display("FAIL R4 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        // ---- Phase A
        do_reset();
        chk("R1 ready", 32'(ready), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        chk("R1 count", 32'(blk_count), 32'd0);

        run_to(NBITS - 1);
        chk("R4 not early", 32'(ready), 32'd0);
        run_to(NBITS);
        chk("R4 buf0 ready", 32'(ready), 32'b01);
        chk("R5 irq", 32'(irq), 32'd1);
        chk("R4 count1", 32'(blk_count), 32'd1);

        rd_chk("R3 hdr0 buf0", 1'b0, 0, 32'd0);
        rd_chk("R3 hdr1 buf0", 1'b0, 1, {16'(PB), 16'd0});
        rd_chk("R2 payload0 buf0 R10", 1'b0, 2, exp_word(0, 0));
        rd_chk("R2 payload1 buf0", 1'b0, 3, exp_word(0, 1));

        run_to(70);
        cyc(1'b1, 1'b0);
        chk("R5 ack clears", 32'(ready), 32'd0);
        chk("R5 irq low", 32'(irq), 32'd0);

        run_to(2 * NBITS);
        chk("R4 buf1 ready", 32'(ready), 32'b10);
        chk("R4 count2", 32'(blk_count), 32'd2);

        cyc(1'b1, 1'b0);
        chk("R6 ack idle buffer", 32'(ready), 32'b10);

        rd_chk("R3 hdr0 buf1", 1'b1, 0, 32'd64);
        rd_chk("R3 hdr1 buf1", 1'b1, 1, {16'(PB), 16'd0});
        rd_chk("R2 payload0 buf1", 1'b1, 2, exp_word(64, 0));
        rd_chk("R2 payload1 buf1", 1'b1, 3, exp_word(64, 1));

        run_to(3 * NBITS);
        chk("R4 both ready", 32'(ready), 32'b11);
        chk("R7 no ovf yet", 32'(overflow), 32'd0);
        cyc(1'b0, 1'b0);
        chk("R7 ovf set", 32'(overflow), 32'd1);
        run_to(200);
        cyc(1'b1, 1'b1);
        chk("R7 buf1 freed", 32'(ready), 32'b01);
        chk("R7 count held", 32'(blk_count), 32'd3);
        cyc(1'b1, 1'b0);
        run_to(201 + NBITS);
        chk("R7 resumed block done", 32'(ready), 32'b10);
        chk("R7 count4", 32'(blk_count), 32'd4);
        chk("R7 ovf sticky", 32'(overflow), 32'd1);
        rd_chk("R7 hdr0 gap", 1'b1, 0, 32'd201);
        rd_chk("R7 payload0", 1'b1, 2, exp_word(201, 0));
        rd_chk("R7 payload1", 1'b1, 3, exp_word(201, 1));

        // ---- Phase B
        do_reset();
        chk("R1 ready again", 32'(ready), 32'd0);
        chk("R1 ovf again", 32'(overflow), 32'd0);
        chk("R1 count again", 32'(blk_count), 32'd0);
        run_to(NBITS);
        chk("R1 first target buf0", 32'(ready), 32'b01);
        rd_chk("R1 hdr0 from zero", 1'b0, 0, 32'd0);
        run_to(2 * NBITS - 1);
        cyc(1'b1, 1'b0);
        chk("R8 swap ready", 32'(ready), 32'b10);
        chk("R8 count2", 32'(blk_count), 32'd2);
        cyc(1'b0, 1'b0);
        chk("R8 no ovf", 32'(overflow), 32'd0);
        run_to(3 * NBITS - 1);
        cyc(1'b1, 1'b0);
        chk("R9 completion wins", 32'(ready), 32'b11);
        chk("R9 count3", 32'(blk_count), 32'd3);
        cyc(1'b0, 1'b0);
        chk("R9 ovf after", 32'(overflow), 32'd1);
        rd_chk("R8 hdr0", 1'b0, 0, 32'd128);
        rd_chk("R8 hdr1", 1'b0, 1, {16'(PB), 16'd0});
        rd_chk("R8 payload0", 1'b0, 2, exp_word(128, 0));
        rd_chk("R8 payload1", 1'b0, 3, exp_word(128, 1));

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule